// File: doc/BRIEF.md
# Load-use stall controller

This block sits in the decode stage of a five-stage in-order pipeline. It detects the one data dependency that operand bypassing cannot cover: the instruction in execute is a load, and the instruction in decode reads the register that load will write. The loaded value only exists at the end of the memory stage. The consumer therefore has to wait one cycle. After that cycle the bypass network delivers the value.

When the condition holds, the block does three things in the same cycle. It holds the program counter. It holds the fetch/decode latch, so the consumer stays in decode. It clears the decode/execute latch, so a bubble enters execute instead of a second copy of the consumer. In the next cycle the load has moved on to memory. The condition is then false, and the consumer moves into execute.

To make the stall timing visible at the ports, the block includes a small registered model of the program counter and the two latches. An instruction source outside the block supplies, combinationally, the fields of the instruction at the current program counter.

Top module: `ldu_stall_unit`

## Requirements
- R1: A stall is raised in any cycle in which a valid load is in execute and the instruction in decode reads that load's destination register through source 1 or source 2.
- R2: During a stall, `pc_we_o` and `ifid_we_o` are both 0 and `idex_bubble_o` is 1, all in the same cycle. Outside a stall, the first two are 1 and the third is 0.
- R3: Each load-use stall lasts exactly one cycle. In the next cycle, execute holds a bubble (`ex_valid_o`=0), and in the cycle after that execute holds the held consumer.
- R4: A load whose destination is register 0 never causes a stall.
- R5: A source field whose use flag is 0 never causes a stall, even when it equals the load's destination.
- R6: A non-load instruction in execute never causes a stall, whatever its destination.
- R7: A load that directly follows another load with the same destination does not stall, unless it reads that register itself. The instruction that follows the second load stalls when it reads that register.
- R8: After reset, `pc_o` is 0, execute is empty, and no stall is raised.
- R9: In every cycle without a stall, the program counter advances by exactly one. During a stall it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_is_load_i | input | 1 | Instruction at `pc_o` is a load |
| fetch_rd_i | input | REG_W | Destination register of the fetched instruction |
| fetch_rs1_i | input | REG_W | Source 1 register index |
| fetch_rs1_use_i | input | 1 | Source 1 is actually read |
| fetch_rs2_i | input | REG_W | Source 2 register index |
| fetch_rs2_use_i | input | 1 | Source 2 is actually read |
| pc_o | output | PC_W | Current fetch address |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode latch write enable |
| idex_bubble_o | output | 1 | Clears the control fields entering execute |
| ex_valid_o | output | 1 | Execute holds a real instruction |
| ex_pc_o | output | PC_W | Address of the instruction in execute |
| ex_is_load_o | output | 1 | Instruction in execute is a load |
| ex_rd_o | output | REG_W | Destination register of the instruction in execute |

## Verification
The assertions assume that the fetch inputs are stable, well-defined functions of `pc_o` in every cycle. They also assume the program counter never wraps during a run, so a step of one can always be observed. The stimulus keeps to both assumptions. A fixed program table is indexed by `pc_o` and is shorter than the address space. That table has a hand-written opening section, which covers load chains, register 0 and unused sources. The rest is a hashed mix of loads and consumers over only four registers, so that matches between destinations and sources happen often.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int unsigned DEF_REG_W = 5;
  localparam int unsigned DEF_PC_W  = 8;
endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
  parameter int unsigned REG_W = ldu_pkg::DEF_REG_W
) (
  input  logic             id_valid_i,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic             id_rs1_use_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_rs2_use_i,
  input  logic             ex_valid_i,
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] ex_rd_i,
  output logic             stall_o
);
  logic [1:0] src_hit;
  logic       load_live;

  // register 0 is never a real destination
  assign load_live  = ex_valid_i && ex_is_load_i && (ex_rd_i != '0);
  assign src_hit[0] = id_rs1_use_i && (id_rs1_i == ex_rd_i);
  assign src_hit[1] = id_rs2_use_i && (id_rs2_i == ex_rd_i);
  assign stall_o    = id_valid_i && load_live && (|src_hit);
endmodule

// File: rtl/ldu_pc_reg.sv
module ldu_pc_reg #(
  parameter int unsigned PC_W = ldu_pkg::DEF_PC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_o <= '0;
    else if (we_i) pc_o <= pc_o + PC_W'(1);
  end
endmodule

// File: rtl/ldu_pipe_regs.sv
module ldu_pipe_regs #(
  parameter int unsigned REG_W = ldu_pkg::DEF_REG_W,
  parameter int unsigned PC_W  = ldu_pkg::DEF_PC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ifid_we_i,
  input  logic             bubble_i,
  input  logic [PC_W-1:0]  f_pc_i,
  input  logic             f_is_load_i,
  input  logic [REG_W-1:0] f_rd_i,
  input  logic [REG_W-1:0] f_rs1_i,
  input  logic             f_rs1_use_i,
  input  logic [REG_W-1:0] f_rs2_i,
  input  logic             f_rs2_use_i,
  output logic             id_valid_o,
  output logic [REG_W-1:0] id_rs1_o,
  output logic             id_rs1_use_o,
  output logic [REG_W-1:0] id_rs2_o,
  output logic             id_rs2_use_o,
  output logic             ex_valid_o,
  output logic             ex_is_load_o,
  output logic [REG_W-1:0] ex_rd_o,
  output logic [PC_W-1:0]  ex_pc_o
);
  typedef struct packed {
    logic             valid;
    logic [PC_W-1:0]  pc;
    logic             is_load;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic             rs1_use;
    logic [REG_W-1:0] rs2;
    logic             rs2_use;
  } ifid_t;

  typedef struct packed {
    logic             valid;
    logic [PC_W-1:0]  pc;
    logic             is_load;
    logic [REG_W-1:0] rd;
  } idex_t;

  ifid_t ifid_q;
  idex_t idex_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_q <= '0;
    end else if (ifid_we_i) begin
      ifid_q <= '{valid: 1'b1, pc: f_pc_i, is_load: f_is_load_i, rd: f_rd_i,
                  rs1: f_rs1_i, rs1_use: f_rs1_use_i,
                  rs2: f_rs2_i, rs2_use: f_rs2_use_i};
    end
  end

  // bubble zeroes every control field entering execute
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idex_q <= '0;
    else if (bubble_i) idex_q <= '0;
    else idex_q <= '{valid: ifid_q.valid, pc: ifid_q.pc,
                     is_load: ifid_q.is_load, rd: ifid_q.rd};
  end

  assign id_valid_o   = ifid_q.valid;
  assign id_rs1_o     = ifid_q.rs1;
  assign id_rs1_use_o = ifid_q.rs1_use;
  assign id_rs2_o     = ifid_q.rs2;
  assign id_rs2_use_o = ifid_q.rs2_use;
  assign ex_valid_o   = idex_q.valid;
  assign ex_is_load_o = idex_q.is_load;
  assign ex_rd_o      = idex_q.rd;
  assign ex_pc_o      = idex_q.pc;
endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit #(
  parameter int unsigned REG_W = ldu_pkg::DEF_REG_W,
  parameter int unsigned PC_W  = ldu_pkg::DEF_PC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_is_load_i,
  input  logic [REG_W-1:0] fetch_rd_i,
  input  logic [REG_W-1:0] fetch_rs1_i,
  input  logic             fetch_rs1_use_i,
  input  logic [REG_W-1:0] fetch_rs2_i,
  input  logic             fetch_rs2_use_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             idex_bubble_o,
  output logic             ex_valid_o,
  output logic [PC_W-1:0]  ex_pc_o,
  output logic             ex_is_load_o,
  output logic [REG_W-1:0] ex_rd_o
);
  logic             stall;
  logic             id_valid, id_rs1_use, id_rs2_use;
  logic [REG_W-1:0] id_rs1, id_rs2;

  ldu_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (pc_we_o),
    .pc_o  (pc_o)
  );

  ldu_pipe_regs #(.REG_W(REG_W), .PC_W(PC_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ifid_we_i   (ifid_we_o),
    .bubble_i    (idex_bubble_o),
    .f_pc_i      (pc_o),
    .f_is_load_i (fetch_is_load_i),
    .f_rd_i      (fetch_rd_i),
    .f_rs1_i     (fetch_rs1_i),
    .f_rs1_use_i (fetch_rs1_use_i),
    .f_rs2_i     (fetch_rs2_i),
    .f_rs2_use_i (fetch_rs2_use_i),
    .id_valid_o  (id_valid),
    .id_rs1_o    (id_rs1),
    .id_rs1_use_o(id_rs1_use),
    .id_rs2_o    (id_rs2),
    .id_rs2_use_o(id_rs2_use),
    .ex_valid_o  (ex_valid_o),
    .ex_is_load_o(ex_is_load_o),
    .ex_rd_o     (ex_rd_o),
    .ex_pc_o     (ex_pc_o)
  );

  ldu_hazard_detect #(.REG_W(REG_W)) u_haz (
    .id_valid_i  (id_valid),
    .id_rs1_i    (id_rs1),
    .id_rs1_use_i(id_rs1_use),
    .id_rs2_i    (id_rs2),
    .id_rs2_use_i(id_rs2_use),
    .ex_valid_i  (ex_valid_o),
    .ex_is_load_i(ex_is_load_o),
    .ex_rd_i     (ex_rd_o),
    .stall_o     (stall)
  );

  // three coordinated actions per stall
  assign pc_we_o       = !stall;
  assign ifid_we_o     = !stall;
  assign idex_bubble_o = stall;
endmodule

// File: rtl/ldu_stall_unit_chk.sv
module ldu_stall_unit_chk #(
  parameter int unsigned REG_W = ldu_pkg::DEF_REG_W,
  parameter int unsigned PC_W  = ldu_pkg::DEF_PC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PC_W-1:0]  pc_o,
  input logic             pc_we_o,
  input logic             ifid_we_o,
  input logic             idex_bubble_o,
  input logic             ex_valid_o,
  input logic [PC_W-1:0]  ex_pc_o,
  input logic             ex_is_load_o,
  input logic [REG_W-1:0] ex_rd_o
);
  AST_STALL_TRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> (!pc_we_o && !ifid_we_o)); // R2
  AST_NO_STALL_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_bubble_o |-> (pc_we_o && ifid_we_o)); // R2
  AST_ONE_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> (!idex_bubble_o && !ex_valid_o)); // R3
  AST_CONSUMER_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> ##1 (ex_valid_o && ex_pc_o == PC_W'($past(ex_pc_o, 2) + 1))); // R3
  AST_ZERO_RD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_o && ex_rd_o == '0) |-> !idex_bubble_o); // R4
  AST_NONLOAD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_is_load_o |-> !idex_bubble_o); // R6
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> $stable(pc_o)); // R9
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_bubble_o |=> (pc_o == PC_W'($past(pc_o) + 1))); // R9
endmodule

bind ldu_stall_unit ldu_stall_unit_chk #(.REG_W(REG_W), .PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_o         (pc_o),
  .pc_we_o      (pc_we_o),
  .ifid_we_o    (ifid_we_o),
  .idex_bubble_o(idex_bubble_o),
  .ex_valid_o   (ex_valid_o),
  .ex_pc_o      (ex_pc_o),
  .ex_is_load_o (ex_is_load_o),
  .ex_rd_o      (ex_rd_o)
);

// File: tb/ldu_stall_unit_test.sv
module ldu_stall_unit_test;
  localparam int unsigned REG_W = 2;
  localparam int unsigned PC_W  = 10;
  localparam int N    = 768;
  localparam int TMAX = 2 * N + 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic             f_ld, f_u1, f_u2;
  logic [REG_W-1:0] f_rd, f_r1, f_r2;
  logic [PC_W-1:0]  pc;
  logic             pc_we, ifid_we, bubble, ex_valid, ex_ld;
  logic [PC_W-1:0]  ex_pc;
  logic [REG_W-1:0] ex_rd;

  logic             p_ld [2**PC_W];
  logic [REG_W-1:0] p_rd [2**PC_W];
  logic [REG_W-1:0] p_r1 [2**PC_W];
  logic [REG_W-1:0] p_r2 [2**PC_W];
  logic             p_u1 [2**PC_W];
  logic             p_u2 [2**PC_W];

  int tr_pc [TMAX];
  int tr_len;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always_comb begin
    f_ld = p_ld[pc]; f_rd = p_rd[pc];
    f_r1 = p_r1[pc]; f_u1 = p_u1[pc];
    f_r2 = p_r2[pc]; f_u2 = p_u2[pc];
  end

  ldu_stall_unit #(.REG_W(REG_W), .PC_W(PC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_is_load_i(f_ld), .fetch_rd_i(f_rd),
    .fetch_rs1_i(f_r1), .fetch_rs1_use_i(f_u1),
    .fetch_rs2_i(f_r2), .fetch_rs2_use_i(f_u2),
    .pc_o(pc), .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(bubble),
    .ex_valid_o(ex_valid), .ex_pc_o(ex_pc), .ex_is_load_o(ex_ld), .ex_rd_o(ex_rd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ins(input int k, input bit ld, input int rd, input int r1,
                         input bit u1, input int r2, input bit u2);
    p_ld[k] = ld; p_rd[k] = REG_W'(rd);
    p_r1[k] = REG_W'(r1); p_u1[k] = u1;
    p_r2[k] = REG_W'(r2); p_u2[k] = u2;
  endtask

  // expected dependency between producer a and consumer b
  function automatic bit dep(input int a, input int b);
    return p_ld[a] && p_rd[a] != 0 &&
           ((p_u1[b] && p_r1[b] == p_rd[a]) || (p_u2[b] && p_r2[b] == p_rd[a]));
  endfunction

  function automatic string tag(input int a, input int b);
    if (!p_ld[a]) return "R6";
    if (p_rd[a] == 0) return "R4";
    if (dep(a, b)) return "R1";
    if (p_ld[b] && p_rd[b] == p_rd[a]) return "R7";
    return "R5";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int last_real;
    for (int k = 0; k < 2**PC_W; k++) set_ins(k, 0, 0, 0, 0, 0, 0);
    // directed opening: back-to-back loads, register 0, unused sources
    set_ins(0, 1, 1, 2, 1, 0, 0);
    set_ins(1, 1, 1, 3, 1, 0, 0);  // R7: same rd, no read of r1
    set_ins(2, 0, 2, 1, 1, 0, 0);  // R7: consumer of second load stalls
    set_ins(3, 1, 0, 2, 1, 0, 0);
    set_ins(4, 0, 3, 0, 1, 0, 1);  // R4: reads r0 after load r0
    set_ins(5, 1, 2, 0, 0, 0, 0);
    set_ins(6, 0, 1, 0, 0, 2, 1);  // R1: match on source 2
    set_ins(7, 1, 3, 0, 0, 0, 0);
    set_ins(8, 0, 1, 3, 0, 3, 0);  // R5: matches but unused
    set_ins(9, 0, 3, 0, 0, 0, 0);
    set_ins(10, 0, 1, 3, 1, 3, 1); // R6: non-load producer
    set_ins(11, 1, 2, 1, 1, 0, 0);
    set_ins(12, 1, 3, 2, 1, 0, 0); // load consumer of load: stalls
    set_ins(13, 0, 0, 3, 1, 3, 1);
    for (int k = 14; k < N; k++) begin
      int h;
      h = (k * 37) ^ (k >> 3) ^ (k * 5 >> 2);
      set_ins(k, h[0] | h[4], h[2:1], h[6:5], h[3] | h[9], h[8:7], h[10] ^ h[1]);
    end
    // expected execute trace: -1 marks a bubble
    tr_len = 0;
    tr_pc[tr_len++] = 0;
    for (int j = 1; j < N; j++) begin
      if (dep(j - 1, j)) tr_pc[tr_len++] = -1;
      tr_pc[tr_len++] = j;
    end

    #5;
    chk("R8 pc", int'(pc), 0);
    chk("R8 ex_valid", int'(ex_valid), 0);
    chk("R8 bubble", int'(bubble), 0);
    @(negedge clk); rst_ni = 1'b1;
    chk("R8 pc_we", int'(pc_we), 1);
    @(posedge clk); @(posedge clk);
    last_real = 0;
    for (int t = 0; t < tr_len; t++) begin
      bit st;
      string rq;
      @(negedge clk);
      st = (t + 1 < tr_len) && (tr_pc[t + 1] < 0);
      if (tr_pc[t] >= 0) begin
        last_real = tr_pc[t];
        chk("R3 ex_valid", int'(ex_valid), 1);
        chk("R3 ex_pc", int'(ex_pc), tr_pc[t]);
        rq = (last_real + 1 < N) ? tag(last_real, last_real + 1) : "R6";
        chk(rq, int'(bubble), int'(st));
      end else begin
        chk("R3 bubble in ex", int'(ex_valid), 0);
        chk("R3 no repeat stall", int'(bubble), 0);
      end
      chk("R2 pc_we", int'(pc_we), int'(!st));
      chk("R2 ifid_we", int'(ifid_we), int'(!st));
      chk("R9 pc", int'(pc), (last_real + 2) % (2**PC_W));
      @(posedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule